// File: doc/BRIEF.md
# Multi-format Audio Serial Receiver

This block takes a three-wire stereo audio link (bit clock, frame clock, serial data) and turns it into a pair of parallel 24-bit sample words, one for the left channel and one for the right. A two-bit format input picks one of four framings. Two of them are right-aligned, with 16-bit or 24-bit samples. One is left-aligned with 24-bit samples. The last is I2S-style, where the first data bit comes one bit slot after the frame-clock change.

The serial lines are oversampled by a faster system clock. The three lines pass through a shared synchronizer, and rising bit-clock edges are detected in the system clock domain. From that point on, every decision is made once per received bit. Each completed frame produces a single strobe, and both words update in that same cycle. Sixteen-bit samples are placed in the upper bits of the 24-bit word, so the sign is kept. When a half-frame ends with fewer bit clocks than the selected format needs, the block reports a framing error.

Top module: `audio_serial_rx`

## Requirements
- R1: With `fmt_i` = 0 (16-bit right-aligned), the last 16 bits before each frame-clock change form the sample, with the MSB first. Earlier bits in the half-frame are ignored. The output word is the sample shifted left by 8 bits.
- R2: With `fmt_i` = 1 (24-bit right-aligned), the last 24 bits before each frame-clock change form the sample. Leading bits in the half-frame are ignored.
- R3: With `fmt_i` = 2 (24-bit left-aligned), the MSB is the first bit after the frame-clock change. The sample is the first 24 bits of the half-frame, and bits after the 24th are ignored.
- R4: With `fmt_i` = 3 (I2S-style), the MSB arrives one bit after the frame-clock change. A half-frame of exactly 16 bit clocks carries a 16-bit sample, which is output shifted left by 8. A half-frame of 24 or more bit clocks carries a 24-bit sample. When the half-frame is only as long as the sample, its LSB falls in the first bit slot of the next half-frame.
- R5: The left sample occupies the first half-frame of each frame and the right sample the second. The left half-frame is marked by frame clock high in formats 0 to 2 and by frame clock low in format 3.
- R6: Data is two's complement and is sampled on the rising bit-clock edge. The codes 7FFFFF, 800000 and 000000 pass through unchanged.
- R7: `valid_o` pulses high for exactly one system cycle for each complete left/right pair. `left_o` and `right_o` change only in that cycle.
- R8: `frame_err_o` pulses when a half-frame ends shorter than the format allows. The limits are 16 bit clocks for format 0, 24 for formats 1 and 2, and exactly 16 or at least 24 for format 3. A frame with such a half produces no `valid_o`. No error is reported for valid lengths.
- R9: After reset, `left_o` and `right_o` are zero and both strobes are low. Nothing is captured or flagged before the first frame-clock change has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than the bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fmt_i | input | 2 | Framing select, 0 to 3 |
| bit_clk_i | input | 1 | Serial bit clock |
| frame_clk_i | input | 1 | Frame clock marking the channel halves |
| ser_data_i | input | 1 | Serial data, MSB first |
| left_o | output | 24 | Left sample word |
| right_o | output | 24 | Right sample word |
| valid_o | output | 1 | One-cycle strobe: a new pair is on the outputs |
| frame_err_o | output | 1 | One-cycle strobe: a half-frame was too short |

## Verification
At the frame-clock change, two things can happen on the same received bit: one channel's word completes, and the next half-frame begins. In the I2S-style framing with exactly 16 or 24 bit clocks per half, the LSB of the previous sample also arrives in that same slot. The bench provokes this with back-to-back exact-length frames that use distinct, asymmetric values for the two channels. It judges the result by checking that every captured pair matches, with no swap and no bit slip, and that the number of strobes is exact.

// File: rtl/asr_pkg.sv
package asr_pkg;

    localparam int unsigned WORD_W   = 24;
    localparam int unsigned NARROW_W = 16;
    localparam int unsigned PAD_W    = WORD_W - NARROW_W;

    typedef enum logic [1:0] {
        FMT_RJ16 = 2'd0,
        FMT_RJ24 = 2'd1,
        FMT_LJ24 = 2'd2,
        FMT_I2S  = 2'd3
    } fmt_e;

endpackage

// File: rtl/asr_sync.sv
module asr_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) stg_q[s] <= '0;
                else         stg_q[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) stg_q[s] <= '0;
                else         stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/asr_bitstrobe.sv
module asr_bitstrobe (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sclk_i,
    input  logic frm_i,
    input  logic dat_i,
    output logic stb_o,
    output logic frm_o,
    output logic dat_o
);

    typedef struct packed {
        logic sclk;
        logic stb;
        logic frm;
        logic dat;
    } bs_t;

    bs_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sclk = sclk_i;
        s_d.stb  = sclk_i & ~s_q.sclk;
        if (sclk_i & ~s_q.sclk) begin
            s_d.frm = frm_i;
            s_d.dat = dat_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign stb_o = s_q.stb;
    assign frm_o = s_q.frm;
    assign dat_o = s_q.dat;

    // R6: one strobe per rising bit-clock edge, never two in a row
    a_r6_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stb_o |=> !stb_o);

    // R6: the strobe follows a low-to-high change of the synchronized bit clock
    a_r6_strobe_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(stb_o) |-> $past(sclk_i));

endmodule

// File: rtl/asr_framer.sv
module asr_framer
    import asr_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [1:0]        fmt_i,
    input  logic              bit_stb_i,
    input  logic              frm_i,
    input  logic              dat_i,
    output logic [WORD_W-1:0] left_o,
    output logic [WORD_W-1:0] right_o,
    output logic              valid_o,
    output logic              err_o
);

    localparam logic [CNT_W-1:0] CNT_MAX     = '1;
    localparam logic [CNT_W-1:0] LEN_NARROW  = CNT_W'(NARROW_W);
    localparam logic [CNT_W-1:0] LEN_WIDE    = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] IDX_LJ_LAST = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] IDX_I2S_END = CNT_W'(WORD_W);

    typedef struct packed {
        logic              seen;
        logic              prev_frm;
        logic              synced;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] sr;
        logic [WORD_W-1:0] lhold;
        logic              lok;
        logic [WORD_W-1:0] lout;
        logic [WORD_W-1:0] rout;
        logic              valid;
        logic              err;
    } fr_t;

    fr_t s_d, s_q;

    fmt_e              fmt;
    logic              bnd;
    logic [CNT_W-1:0]  idx;
    logic [CNT_W-1:0]  len;
    logic [WORD_W-1:0] sr_n;
    logic [WORD_W-1:0] word;
    logic              hit;
    logic              chan_frm;
    logic              short_half;
    logic              is_left;

    always_comb begin
        fmt        = fmt_e'(fmt_i);
        bnd        = s_q.seen && (frm_i != s_q.prev_frm);
        idx        = bnd ? '0 : s_q.cnt;
        len        = s_q.cnt;
        sr_n       = {s_q.sr[WORD_W-2:0], dat_i};
        word       = '0;
        hit        = 1'b0;
        chan_frm   = frm_i;
        short_half = 1'b0;

        // pick the latch point and word layout of the selected framing
        unique case (fmt)
            FMT_RJ16: begin
                short_half = len < LEN_NARROW;
                hit        = bnd && !short_half;
                chan_frm   = s_q.prev_frm;
                word       = {s_q.sr[NARROW_W-1:0], {PAD_W{1'b0}}};
            end
            FMT_RJ24: begin
                short_half = len < LEN_WIDE;
                hit        = bnd && !short_half;
                chan_frm   = s_q.prev_frm;
                word       = s_q.sr;
            end
            FMT_LJ24: begin
                short_half = len < LEN_WIDE;
                hit        = !bnd && (idx == IDX_LJ_LAST);
                chan_frm   = frm_i;
                word       = sr_n;
            end
            FMT_I2S: begin
                short_half = (len < LEN_WIDE) && (len != LEN_NARROW);
                if (bnd) begin
                    chan_frm = s_q.prev_frm;
                    if (len == LEN_NARROW) begin
                        hit  = 1'b1;
                        word = {s_q.sr[NARROW_W-2:0], dat_i, {PAD_W{1'b0}}};
                    end else if (len == LEN_WIDE) begin
                        hit  = 1'b1;
                        word = sr_n;
                    end
                end else if (idx == IDX_I2S_END) begin
                    hit      = 1'b1;
                    chan_frm = frm_i;
                    word     = sr_n;
                end
            end
            default: ;
        endcase

        is_left = (fmt == FMT_I2S) ? !chan_frm : chan_frm;

        s_d       = s_q;
        s_d.valid = 1'b0;
        s_d.err   = 1'b0;

        if (bit_stb_i) begin
            s_d.seen     = 1'b1;
            s_d.prev_frm = frm_i;
            s_d.sr       = sr_n;
            if (bnd) begin
                s_d.cnt    = CNT_W'(1);
                s_d.synced = 1'b1;
            end else if (s_q.cnt != CNT_MAX) begin
                s_d.cnt = s_q.cnt + CNT_W'(1);
            end

            if (s_q.synced) begin
                if (bnd && short_half) begin
                    s_d.err = 1'b1;
                    s_d.lok = 1'b0;
                end
                if (hit) begin
                    if (is_left) begin
                        s_d.lhold = word;
                        s_d.lok   = 1'b1;
                    end else if (s_q.lok) begin
                        s_d.lout  = s_q.lhold;
                        s_d.rout  = word;
                        s_d.valid = 1'b1;
                        s_d.lok   = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign left_o  = s_q.lout;
    assign right_o = s_q.rout;
    assign valid_o = s_q.valid;
    assign err_o   = s_q.err;

    // R7: the pair strobe lasts one cycle
    a_r7_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> !valid_o);

    // R7: a strobe is always caused by a received bit
    a_r7_valid_after_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> $past(bit_stb_i));

    // R7: the words hold their value between strobes
    a_r7_words_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_o |-> ($stable(left_o) && $stable(right_o)));

    // R8: a framing error never coincides with a delivered pair
    a_r8_err_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(err_o && valid_o));

    // R8: errors are only reported once a received bit has ended a half-frame
    a_r8_err_after_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> $past(bit_stb_i));

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
    import asr_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CNT_W       = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [1:0]        fmt_i,
    input  logic              bit_clk_i,
    input  logic              frame_clk_i,
    input  logic              ser_data_i,
    output logic [WORD_W-1:0] left_o,
    output logic [WORD_W-1:0] right_o,
    output logic              valid_o,
    output logic              frame_err_o
);

    localparam int unsigned LINES = 3;

    logic [LINES-1:0] lines_sync;
    logic             bit_stb;
    logic             bit_frm;
    logic             bit_dat;

    asr_sync #(
        .WIDTH  (LINES),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    ({bit_clk_i, frame_clk_i, ser_data_i}),
        .q_o    (lines_sync)
    );

    asr_bitstrobe i_bitstrobe (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sclk_i (lines_sync[2]),
        .frm_i  (lines_sync[1]),
        .dat_i  (lines_sync[0]),
        .stb_o  (bit_stb),
        .frm_o  (bit_frm),
        .dat_o  (bit_dat)
    );

    asr_framer #(
        .CNT_W (CNT_W)
    ) i_framer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .fmt_i     (fmt_i),
        .bit_stb_i (bit_stb),
        .frm_i     (bit_frm),
        .dat_i     (bit_dat),
        .left_o    (left_o),
        .right_o   (right_o),
        .valid_o   (valid_o),
        .err_o     (frame_err_o)
    );

endmodule

// File: tb/test_audio_serial_rx.sv
module test_audio_serial_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fmt = 2'd0;
    logic        bclk = 1'b0;
    logic        fclk = 1'b0;
    logic        sdat = 1'b0;
    logic [23:0] left_w, right_w;
    logic        valid, ferr;

    int checks = 0;
    int fails  = 0;

    logic [23:0] cap_l [8];
    logic [23:0] cap_r [8];
    int          n_val = 0;
    int          n_err = 0;
    int          n_unstable = 0;
    logic [23:0] prev_l = '0, prev_r = '0;
    logic        carry = 1'b0;

    logic [23:0] ex_l [4];
    logic [23:0] ex_r [4];

    always #2.5 clk = ~clk;

    audio_serial_rx i_audio_serial_rx (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .fmt_i       (fmt),
        .bit_clk_i   (bclk),
        .frame_clk_i (fclk),
        .ser_data_i  (sdat),
        .left_o      (left_w),
        .right_o     (right_w),
        .valid_o     (valid),
        .frame_err_o (ferr)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (valid) begin
                if (n_val < 8) begin
                    cap_l[n_val] = left_w;
                    cap_r[n_val] = right_w;
                end
                n_val++;
            end else if (left_w !== prev_l || right_w !== prev_r) begin
                n_unstable++;
            end
            if (ferr) n_err++;
        end
        prev_l = left_w;
        prev_r = right_w;
    end

    task automatic check(input string tag, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic bit_out(input logic f, input logic d);
        @(negedge clk);
        fclk = f;
        sdat = d;
        repeat (4) @(negedge clk);
        bclk = 1'b1;
        repeat (4) @(negedge clk);
        bclk = 1'b0;
    endtask

    function automatic logic half_bit(input int f, input int h, input logic [23:0] w,
                                      input int idx, input logic junk);
        int wid;
        case (f)
            0: return (idx >= h - 16) ? w[h-1-idx] : junk;
            1: return (idx >= h - 24) ? w[h-1-idx] : junk;
            2: return (idx < 24) ? w[23-idx] : junk;
            default: begin
                wid = (h == 16) ? 16 : 24;
                return (idx >= 1 && idx <= wid) ? w[wid-idx] : junk;
            end
        endcase
    endfunction

    task automatic send_half(input int f, input int h, input logic lv, input logic [23:0] w,
                             input logic junk);
        int wid;
        wid = (h == 16) ? 16 : 24;
        for (int i = 0; i < h; i++) begin
            if (f == 3 && i == 0) bit_out(lv, carry);
            else                  bit_out(lv, half_bit(f, h, w, i, junk));
        end
        carry = (f == 3 && wid == h) ? w[0] : junk;
    endtask

    task automatic send_frame(input int f, input int h, input logic [23:0] l,
                              input logic [23:0] r, input logic junk);
        logic lv;
        lv = (f == 3) ? 1'b0 : 1'b1;
        send_half(f, h, lv, l, junk);
        send_half(f, h, ~lv, r, junk);
    endtask

    task automatic do_reset(input int f);
        @(negedge clk);
        rst_n = 1'b0;
        fmt   = 2'(f);
        bclk  = 1'b0;
        fclk  = (f == 3) ? 1'b1 : 1'b0;
        sdat  = 1'b0;
        carry = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        n_val = 0;
        n_err = 0;
        n_unstable = 0;
    endtask

    // run nfr frames from ex_l/ex_r, flush with one zero frame, then judge
    task automatic run_case(input string tag, input int f, input int h, input int nfr,
                            input logic junk);
        logic [23:0] el, er;
        int          exp_n;
        logic        narrow;
        do_reset(f);
        for (int i = 0; i < 4; i++) bit_out((f == 3) ? 1'b1 : 1'b0, junk);
        for (int k = 0; k < nfr; k++) send_frame(f, h, ex_l[k], ex_r[k], junk);
        send_frame(f, h, 24'h0, 24'h0, 1'b0);
        repeat (12) @(negedge clk);
        narrow = (f == 0) || (f == 3 && h == 16);
        exp_n  = nfr + (((f == 2) || (f == 3 && h > 24)) ? 1 : 0);
        check(tag, "strobe count (R7)", n_val, exp_n);
        check(tag, "no framing error (R8)", n_err, 0);
        check(tag, "words hold between strobes (R7)", n_unstable, 0);
        for (int k = 0; k < nfr; k++) begin
            el = narrow ? {ex_l[k][15:0], 8'h00} : ex_l[k];
            er = narrow ? {ex_r[k][15:0], 8'h00} : ex_r[k];
            check(tag, "left word (R5)", cap_l[k], el);
            check(tag, "right word (R5)", cap_r[k], er);
        end
    endtask

    task automatic test_reset;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R9", "left after reset", left_w, 0);
        check("R9", "right after reset", right_w, 0);
        check("R9", "valid after reset", valid, 0);
        check("R9", "error after reset", ferr, 0);
        // frame clock idle, bit clock running: nothing may be captured or flagged
        do_reset(1);
        for (int i = 0; i < 40; i++) bit_out(1'b0, 1'b1);
        repeat (12) @(negedge clk);
        check("R9", "no strobe before first edge", n_val, 0);
        check("R9", "no error before first edge", n_err, 0);
    endtask

    task automatic test_rj16;
        ex_l[0] = 24'h00_7FFF; ex_r[0] = 24'h00_8000;
        ex_l[1] = 24'h00_1234; ex_r[1] = 24'h00_C3A5;
        run_case("R1", 0, 16, 2, 1'b0);
        ex_l[0] = 24'h00_A5F0; ex_r[0] = 24'h00_0F0E;
        ex_l[1] = 24'h00_0001; ex_r[1] = 24'h00_FFFE;
        run_case("R1", 0, 32, 2, 1'b1);
    endtask

    task automatic test_rj24;
        ex_l[0] = 24'h7FFFFF; ex_r[0] = 24'h800000;
        ex_l[1] = 24'h000000; ex_r[1] = 24'hA5C3E1;
        ex_l[2] = 24'h123456; ex_r[2] = 24'hFEDCBA;
        run_case("R2", 1, 32, 3, 1'b1);
        check("R6", "full-scale positive", cap_l[0], 24'h7FFFFF);
        check("R6", "full-scale negative", cap_r[0], 24'h800000);
        check("R6", "midscale", cap_l[1], 24'h000000);
        ex_l[0] = 24'h3C5A96; ex_r[0] = 24'hC001D0;
        run_case("R2", 1, 24, 1, 1'b0);
    endtask

    task automatic test_lj24;
        ex_l[0] = 24'h89ABCD; ex_r[0] = 24'h13579B;
        ex_l[1] = 24'h7FFFFF; ex_r[1] = 24'h800001;
        run_case("R3", 2, 32, 2, 1'b1);
        ex_l[0] = 24'h0F1E2D; ex_r[0] = 24'hF0E1D2;
        run_case("R3", 2, 24, 1, 1'b0);
    endtask

    task automatic test_i2s;
        ex_l[0] = 24'hB16B00; ex_r[0] = 24'h2468AC;
        ex_l[1] = 24'h800000; ex_r[1] = 24'h7FFFFF;
        run_case("R4", 3, 32, 2, 1'b1);
        ex_l[0] = 24'hC0FFEE; ex_r[0] = 24'h1D2E3F;
        ex_l[1] = 24'h000001; ex_r[1] = 24'hFFFFFE;
        run_case("R4", 3, 24, 2, 1'b0);
        ex_l[0] = 24'h00_8001; ex_r[0] = 24'h00_7FFE;
        ex_l[1] = 24'h00_5A5A; ex_r[1] = 24'h00_A5A4;
        run_case("R4", 3, 16, 2, 1'b0);
    endtask

    task automatic short_case(input string tag, input int f, input int h);
        do_reset(f);
        for (int i = 0; i < 4; i++) bit_out((f == 3) ? 1'b1 : 1'b0, 1'b0);
        send_frame(f, h, 24'h654321, 24'h123456, 1'b0);
        send_frame(f, h, 24'h0, 24'h0, 1'b0);
        repeat (12) @(negedge clk);
        check(tag, "error reported for short half", (n_err != 0), 1);
        check(tag, "no strobe for short frame", n_val, 0);
    endtask

    task automatic test_short;
        short_case("R8", 1, 20);
        short_case("R8", 3, 20);
        short_case("R8", 0, 12);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        test_reset();
        test_rj16();
        test_rj24();
        test_lj24();
        test_i2s();
        test_short();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule